// File: doc/BRIEF.md
# Head-of-Queues Matching Circuit Crossbar

This block is the switching element of a circuit-switched data plane in a 2D mesh. It makes no routing decision of its own and has no virtual channels. A separate control plane routes small reservation packets ahead of the data. Each time a reservation crosses this router, the control plane issues one enqueue strobe naming an input port and an output port. The block stores the reservation twice. The output number goes at the tail of an ordered queue kept for that input. The input number goes at the tail of an ordered queue kept for that output.

A crossbar connection forms only when four things hold at once: the input is idle, the output is idle, the input's oldest entry names that output, and the output's oldest entry names that input. When the connection forms, both head entries are consumed and both ports become busy. Flits then move from the input's buffer to the output link, one per cycle, as long as downstream credits remain. When the tail flit leaves, both ports become free again. Data packets therefore cross each port in the same order in which their reservations crossed it, even when the data arrives in a different order. A flit that arrives before its connection exists waits in the input buffer.

The five ports are numbered 0 to 4 (local, north, east, south, west). The block has one flit buffer per input. Upstream senders are held to the buffer depth by credits.

Top module: `hqx_circuit_xbar`

## Requirements
- R1: After a synchronous reset, every `out_valid` and `in_credit` bit is 0. With both reservation queues empty, `rsv_accept` is 1.
- R2: `rsv_accept` is 1 only when both port numbers are below 5, the queue of input `rsv_src` has room and the queue of output `rsv_dst` has room. A strobe with `rsv_valid`=1 and `rsv_accept`=0 is ignored, and the input named by `rsv_src` never connects to `rsv_dst` because of it.
- R3: A connection from input i to output o forms only when both ports are idle, i's oldest entry is o and o's oldest entry is i. A packet entering input i leaves only on output o.
- R4: An output serves its inputs in the order in which their reservations were accepted, whatever order their flits arrive in.
- R5: A connection holds until its tail flit has left the output. The same ports can then serve later reservations.
- R6: Connections that share no port are realized and forward in the same cycles.
- R7: Each output keeps a credit count that starts at `BUF_DEPTH`, drops by one per flit sent and rises by one per `out_credit` pulse. A flit is sent only while the count is nonzero.
- R8: Flits that arrive before their connection exists stay buffered and produce no output until the connection forms.
- R9: `in_credit[i]` pulses for one cycle for every flit that leaves input i's buffer.
- R10: Flit payloads and tail marks leave unchanged and in arrival order. The payload of port p sits at bits p*FLIT_W upward in `in_data` and `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsv_valid | input | 1 | Reservation strobe from the control plane |
| rsv_src | input | 3 | Input port number of the reservation |
| rsv_dst | input | 3 | Output port number of the reservation |
| rsv_accept | output | 1 | Both queues can take the presented reservation (combinational) |
| in_valid | input | 5 | Flit present on each input link |
| in_tail | input | 5 | Flit on each input link is the last of its packet |
| in_data | input | 5*FLIT_W | Payload of each input link |
| in_credit | output | 5 | One buffer slot freed, per input |
| out_valid | output | 5 | Flit present on each output link (registered) |
| out_tail | output | 5 | Output flit is a tail (registered) |
| out_data | output | 5*FLIT_W | Payload of each output link (registered) |
| out_credit | input | 5 | Downstream slot freed, per output |

## Verification
A corrupted queue head or a wrong busy flag does not stay hidden inside the block. Either a packet shows up on the wrong output link, or it never leaves, and the count of flits per link falls short within a few cycles of the expected delivery. A wrong order between two reservations for the same output shows up as swapped packet tags on that link. A credit count that drifts shows up as flits sent beyond the downstream allowance, or as a stall that does not clear after a credit pulse. Each packet carries a sender tag and a sequence number in its payload, so a single mis-steered or reordered flit is visible at the ports.

// File: rtl/hqx_pkg.sv
package hqx_pkg;
  localparam int unsigned NPORTS = 5;
  localparam int unsigned PW = 3;
  typedef logic [PW-1:0] port_t;
endpackage

// File: rtl/hqx_fifo.sv
module hqx_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  // storage without reset so that RAM inference stays possible
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R2 / R8: writers never push into a full queue or buffer
  a_r2_push_room: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R3: entries are only consumed when present
  a_r3_pop_present: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/hqx_match.sv
module hqx_match
  import hqx_pkg::*;
(
  input  logic [NPORTS-1:0]    in_hv,
  input  logic [NPORTS*PW-1:0] in_head_f,
  input  logic [NPORTS-1:0]    in_busy,
  input  logic [NPORTS-1:0]    out_hv,
  input  logic [NPORTS*PW-1:0] out_head_f,
  input  logic [NPORTS-1:0]    out_busy,
  output logic [NPORTS-1:0]    match_in,
  output logic [NPORTS-1:0]    match_out
);
  // an input matches when the output named at its head names it back
  always_comb begin
    match_in = '0;
    for (int i = 0; i < NPORTS; i++) begin
      for (int o = 0; o < NPORTS; o++) begin
        if (in_hv[i] && !in_busy[i] && in_head_f[i*PW +: PW] == PW'(o) &&
            out_hv[o] && !out_busy[o] && out_head_f[o*PW +: PW] == PW'(i))
          match_in[i] = 1'b1;
      end
    end
  end

  always_comb begin
    match_out = '0;
    for (int o = 0; o < NPORTS; o++) begin
      for (int i = 0; i < NPORTS; i++) begin
        if (match_in[i] && in_head_f[i*PW +: PW] == PW'(o))
          match_out[o] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hqx_circuit_xbar.sv
module hqx_circuit_xbar
  import hqx_pkg::*;
#(
  parameter int unsigned FLIT_W    = 16,
  parameter int unsigned BUF_DEPTH = 14,
  parameter int unsigned RQ_DEPTH  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rsv_valid,
  input  logic [PW-1:0]            rsv_src,
  input  logic [PW-1:0]            rsv_dst,
  output logic                     rsv_accept,
  input  logic [NPORTS-1:0]        in_valid,
  input  logic [NPORTS-1:0]        in_tail,
  input  logic [NPORTS*FLIT_W-1:0] in_data,
  output logic [NPORTS-1:0]        in_credit,
  output logic [NPORTS-1:0]        out_valid,
  output logic [NPORTS-1:0]        out_tail,
  output logic [NPORTS*FLIT_W-1:0] out_data,
  input  logic [NPORTS-1:0]        out_credit
);
  localparam int unsigned CW = $clog2(BUF_DEPTH + 1);
  localparam int unsigned EW = FLIT_W + 1;

  logic [NPORTS-1:0]    iq_empty, iq_full, oq_empty, oq_full;
  logic [NPORTS*PW-1:0] iq_head_f, oq_head_f;
  logic [NPORTS-1:0]    match_in, match_out;
  logic [NPORTS-1:0]    in_busy, out_busy;
  port_t                in_sel [NPORTS];
  logic [NPORTS-1:0]    fb_empty, fb_full;
  logic [EW-1:0]        fb_head [NPORTS];
  logic [CW-1:0]        cred [NPORTS];
  logic [NPORTS-1:0]    cred_ok, send;
  logic [NPORTS-1:0]    o_go, o_last;
  logic [EW-1:0]        o_flit [NPORTS];
  logic [FLIT_W-1:0]    out_d_q [NPORTS];
  logic                 rsv_go, src_room, dst_room;

  // reservation admission
  always_comb begin
    src_room = 1'b0;
    dst_room = 1'b0;
    for (int p = 0; p < NPORTS; p++) begin
      if (rsv_src == PW'(p)) src_room = !iq_full[p];
      if (rsv_dst == PW'(p)) dst_room = !oq_full[p];
    end
  end
  assign rsv_accept = src_room && dst_room;
  assign rsv_go     = rsv_valid && rsv_accept;

  genvar g;
  generate
    for (g = 0; g < NPORTS; g++) begin : g_port
      logic [PW-1:0] iq_h, oq_h;

      // input side: future outputs in reservation order
      hqx_fifo #(.DEPTH(RQ_DEPTH), .W(PW)) u_iq (
        .clk(clk), .rst(rst),
        .push(rsv_go && rsv_src == PW'(g)), .din(rsv_dst),
        .pop(match_in[g]), .head(iq_h),
        .empty(iq_empty[g]), .full(iq_full[g])
      );
      // output side: future inputs in reservation order
      hqx_fifo #(.DEPTH(RQ_DEPTH), .W(PW)) u_oq (
        .clk(clk), .rst(rst),
        .push(rsv_go && rsv_dst == PW'(g)), .din(rsv_src),
        .pop(match_out[g]), .head(oq_h),
        .empty(oq_empty[g]), .full(oq_full[g])
      );
      assign iq_head_f[g*PW +: PW] = iq_h;
      assign oq_head_f[g*PW +: PW] = oq_h;

      // flit buffer of the input link, sized by the credit loop
      hqx_fifo #(.DEPTH(BUF_DEPTH), .W(EW)) u_fb (
        .clk(clk), .rst(rst),
        .push(in_valid[g]), .din({in_tail[g], in_data[g*FLIT_W +: FLIT_W]}),
        .pop(send[g]), .head(fb_head[g]),
        .empty(fb_empty[g]), .full(fb_full[g])
      );

      // input connection state
      always_ff @(posedge clk) begin
        if (rst) begin
          in_busy[g]   <= 1'b0;
          in_sel[g]    <= '0;
          in_credit[g] <= 1'b0;
        end else begin
          in_credit[g] <= send[g];
          if (match_in[g]) begin
            in_busy[g] <= 1'b1;
            in_sel[g]  <= iq_h;
          end else if (send[g] && fb_head[g][EW-1]) begin
            in_busy[g] <= 1'b0;
          end
        end
      end

      // output connection state, credit count and link register
      always_ff @(posedge clk) begin
        if (rst) begin
          out_busy[g]  <= 1'b0;
          cred[g]      <= CW'(BUF_DEPTH);
          out_valid[g] <= 1'b0;
          out_tail[g]  <= 1'b0;
          out_d_q[g]   <= '0;
        end else begin
          if (match_out[g])
            out_busy[g] <= 1'b1;
          else if (o_last[g])
            out_busy[g] <= 1'b0;
          case ({o_go[g], out_credit[g]})
            2'b10:   cred[g] <= cred[g] - CW'(1);
            2'b01:   cred[g] <= cred[g] + CW'(1);
            default: cred[g] <= cred[g];
          endcase
          out_valid[g] <= o_go[g];
          out_tail[g]  <= o_go[g] && o_flit[g][EW-1];
          if (o_go[g]) out_d_q[g] <= o_flit[g][FLIT_W-1:0];
        end
      end
      assign out_data[g*FLIT_W +: FLIT_W] = out_d_q[g];

      // R7: every flit on the link was covered by a credit
      a_r7_credit_gate: assert property (@(posedge clk) disable iff (rst)
        out_valid[g] |-> $past(cred[g]) != '0);
      // R7: the count never exceeds the downstream buffer
      a_r7_credit_cap: assert property (@(posedge clk) disable iff (rst)
        cred[g] <= CW'(BUF_DEPTH));
      // R5: a tail on the link means the output was released
      a_r5_tail_release: assert property (@(posedge clk) disable iff (rst)
        (out_valid[g] && out_tail[g]) |-> !out_busy[g]);
      // R8: upstream respects the credits it was given
      a_r8_buf_room: assert property (@(posedge clk) disable iff (rst)
        in_valid[g] |-> !fb_full[g]);
    end
  endgenerate

  hqx_match u_match (
    .in_hv(~iq_empty), .in_head_f(iq_head_f), .in_busy(in_busy),
    .out_hv(~oq_empty), .out_head_f(oq_head_f), .out_busy(out_busy),
    .match_in(match_in), .match_out(match_out)
  );

  // forwarding: credit looked up through the selected output
  always_comb begin
    for (int i = 0; i < NPORTS; i++) begin
      cred_ok[i] = 1'b0;
      for (int o = 0; o < NPORTS; o++)
        if (in_sel[i] == PW'(o)) cred_ok[i] = (cred[o] != '0);
      send[i] = in_busy[i] && !fb_empty[i] && cred_ok[i];
    end
  end

  always_comb begin
    for (int o = 0; o < NPORTS; o++) begin
      o_go[o]   = 1'b0;
      o_last[o] = 1'b0;
      o_flit[o] = '0;
      for (int i = 0; i < NPORTS; i++) begin
        if (send[i] && in_sel[i] == PW'(o)) begin
          o_go[o]   = 1'b1;
          o_flit[o] = fb_head[i];
          o_last[o] = fb_head[i][EW-1];
        end
      end
    end
  end

  // R3: an output is claimed by at most one active input, and an active input's output is held
  generate
    for (g = 0; g < NPORTS; g++) begin : g_chk
      logic [NPORTS-1:0] claim;
      logic              sel_held;
      always_comb begin
        sel_held = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
          claim[i] = in_busy[i] && in_sel[i] == PW'(g);
          if (in_sel[g] == PW'(i)) sel_held = out_busy[i];
        end
      end
      a_r3_one_claim: assert property (@(posedge clk) disable iff (rst)
        $countones(claim) <= 1);
      a_r5_pair_held: assert property (@(posedge clk) disable iff (rst)
        in_busy[g] |-> sel_held);
    end
  endgenerate
endmodule

// File: tb/hqx_circuit_xbar_test.sv
module hqx_circuit_xbar_test;
  localparam int FW = 8;
  localparam int NP = 5;

  logic          clk = 0;
  logic          rst = 1;
  logic          rsv_valid = 0;
  logic [2:0]    rsv_src = 0, rsv_dst = 0;
  logic          rsv_accept;
  logic [NP-1:0] in_valid = 0, in_tail = 0;
  logic [NP*FW-1:0] in_data = 0;
  logic [NP-1:0] in_credit, out_valid, out_tail;
  logic [NP*FW-1:0] out_data;
  logic [NP-1:0] out_credit = 0;

  logic [NP-1:0] auto_cr = '1;
  logic [NP-1:0] man_cr = '0;
  logic          clr_req = 0;

  logic [8:0] rx [NP][32];
  int rx_n [NP];
  int cr_n [NP];
  int simul_max;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hqx_circuit_xbar #(.FLIT_W(FW), .BUF_DEPTH(4), .RQ_DEPTH(2)) uut (
    .clk(clk), .rst(rst), .rsv_valid(rsv_valid), .rsv_src(rsv_src),
    .rsv_dst(rsv_dst), .rsv_accept(rsv_accept), .in_valid(in_valid),
    .in_tail(in_tail), .in_data(in_data), .in_credit(in_credit),
    .out_valid(out_valid), .out_tail(out_tail), .out_data(out_data),
    .out_credit(out_credit)
  );

  // monitor and downstream credit return, away from the active edge
  always @(negedge clk) begin
    if (clr_req) begin
      for (int p = 0; p < NP; p++) begin rx_n[p] = 0; cr_n[p] = 0; end
      simul_max = 0;
    end else if (!rst) begin
      for (int p = 0; p < NP; p++) begin
        if (out_valid[p]) begin
          if (rx_n[p] < 32) rx[p][rx_n[p]] = {out_tail[p], out_data[p*FW +: FW]};
          rx_n[p]++;
        end
        if (in_credit[p]) cr_n[p]++;
      end
      if ($countones(out_valid) > simul_max) simul_max = $countones(out_valid);
    end
    out_credit <= (out_valid & auto_cr) | man_cr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    @(negedge clk); #1 clr_req = 1;
    @(negedge clk); #1 clr_req = 0;
  endtask

  task automatic reserve(input int s, input int d, output bit acc);
    @(negedge clk);
    rsv_valid = 1; rsv_src = 3'(s); rsv_dst = 3'(d);
    #1 acc = rsv_accept;
    @(negedge clk);
    rsv_valid = 0;
  endtask

  task automatic send_pkt(input int i, input int len, input int tag);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid[i] = 1;
      in_data[i*FW +: FW] = {4'(tag), 4'(k)};
      in_tail[i] = (k == len - 1);
    end
    @(negedge clk);
    in_valid[i] = 0;
    in_tail[i] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pkt(input int o, input int base, input int len, input int tag, input string req);
    for (int k = 0; k < len; k++) begin
      logic [8:0] e;
      e = {(k == len - 1) ? 1'b1 : 1'b0, 4'(tag), 4'(k)};
      chk(rx[o][base+k] == e, req, int'(rx[o][base+k]), int'(e));
    end
  endtask

  task automatic credit_pulse(input int o);
    @(posedge clk); #1 man_cr[o] = 1;
    @(posedge clk); #1 man_cr[o] = 0;
  endtask

  function automatic int others(input int o);
    int s = 0;
    for (int p = 0; p < NP; p++) if (p != o) s += rx_n[p];
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(in_credit == 0, "R1 in_credit", int'(in_credit), 0);
    #1 chk(rsv_accept == 1, "R1 rsv_accept", int'(rsv_accept), 1);

    // R3/R5/R9/R10: every input-output pair, varied length
    for (int i = 0; i < NP; i++) begin
      for (int o = 0; o < NP; o++) begin
        int len, tag;
        len = 1 + ((i + o) % 4);
        tag = (i * 5 + o) % 16;
        clear();
        reserve(i, o, acc);
        chk(acc, "R2 accept", int'(acc), 1);
        send_pkt(i, len, tag);
        idle(10);
        chk(rx_n[o] == len, "R3 delivered", rx_n[o], len);
        chk(others(o) == 0, "R3 no stray", others(o), 0);
        expect_pkt(o, 0, len, tag, "R10 payload");
        chk(cr_n[i] == len, "R9 credits", cr_n[i], len);
      end
    end

    // R8: data before reservation waits
    clear();
    send_pkt(2, 3, 9);
    idle(8);
    chk(others(-1) == 0, "R8 held", others(-1), 0);
    chk(cr_n[2] == 0, "R8 no credit", cr_n[2], 0);
    reserve(2, 4, acc);
    idle(10);
    chk(rx_n[4] == 3, "R8 released", rx_n[4], 3);
    expect_pkt(4, 0, 3, 9, "R8 payload");

    // R4: reservation order wins over arrival order
    clear();
    reserve(0, 3, acc);
    reserve(1, 3, acc);
    send_pkt(1, 2, 11);
    idle(6);
    chk(rx_n[3] == 0, "R4 later waits", rx_n[3], 0);
    send_pkt(0, 3, 10);
    idle(12);
    chk(rx_n[3] == 5, "R4 count", rx_n[3], 5);
    expect_pkt(3, 0, 3, 10, "R4 first");
    expect_pkt(3, 3, 2, 11, "R4 second");

    // R6: disjoint connections in parallel
    clear();
    reserve(0, 1, acc);
    reserve(2, 3, acc);
    reserve(4, 0, acc);
    fork
      send_pkt(0, 4, 1);
      send_pkt(2, 4, 2);
      send_pkt(4, 4, 3);
    join
    idle(10);
    chk(rx_n[1] == 4 && rx_n[3] == 4 && rx_n[0] == 4, "R6 all delivered",
        rx_n[1] + rx_n[3] + rx_n[0], 12);
    chk(simul_max == 3, "R6 concurrent", simul_max, 3);
    expect_pkt(0, 0, 4, 3, "R6 payload");

    // R2: full output queue rejects and the rejected pair never connects
    clear();
    reserve(0, 4, acc);
    chk(acc, "R2 first", int'(acc), 1);
    reserve(1, 4, acc);
    reserve(2, 4, acc);
    chk(acc, "R2 fill", int'(acc), 1);
    reserve(3, 4, acc);
    chk(!acc, "R2 full reject", int'(acc), 0);
    send_pkt(3, 1, 7);
    send_pkt(0, 1, 4);
    send_pkt(1, 1, 5);
    send_pkt(2, 1, 6);
    idle(12);
    chk(rx_n[4] == 3, "R2 ignored", rx_n[4], 3);
    expect_pkt(4, 0, 1, 4, "R4 q0");
    expect_pkt(4, 1, 1, 5, "R4 q1");
    expect_pkt(4, 2, 1, 6, "R4 q2");
    reserve(3, 4, acc);
    chk(acc, "R2 room again", int'(acc), 1);
    idle(8);
    chk(rx_n[4] == 4, "R5 reuse", rx_n[4], 4);
    expect_pkt(4, 3, 1, 7, "R5 payload");

    // R7: credit stall and release
    clear();
    auto_cr[2] = 0;
    reserve(1, 2, acc);
    send_pkt(1, 4, 12);
    idle(10);
    chk(rx_n[2] == 4, "R7 initial credits", rx_n[2], 4);
    reserve(1, 2, acc);
    send_pkt(1, 2, 13);
    idle(10);
    chk(rx_n[2] == 4, "R7 stalled", rx_n[2], 4);
    credit_pulse(2);
    idle(6);
    chk(rx_n[2] == 5, "R7 one credit", rx_n[2], 5);
    credit_pulse(2);
    idle(6);
    chk(rx_n[2] == 6, "R7 two credits", rx_n[2], 6);
    expect_pkt(2, 4, 2, 13, "R7 payload");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule